// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a combinational 32-bit arithmetic and logic unit made from a chain of identical one-bit slices. Every slice holds a full adder, a conditional inverter on its B bit and a four-way result selector. A two-bit operation code picks bitwise AND, bitwise OR, the adder sum or the compare input. A single subtract control inverts B in every slice and also forces the carry into bit 0 to 1, which turns the adder into a subtractor.

The signed compare runs a subtraction and takes the raw sign of the top slice's adder sum. That bit is fed back to the compare input of slice 0, and the compare inputs of all other slices are tied low, so the result is either 1 or 0. The sign is used as is, with no overflow correction. The carry rippling out of bit 31, a signed overflow flag, an all-zero flag for equality tests and the top slice's raw sum bit are brought out as ports.

Top module: `alu_bitslice`

## Requirements
- R1: With op_i = 2'b00 the result is A AND B', where B' is B_i when sub_i = 0 and the bitwise inverse of B_i when sub_i = 1.
- R2: With op_i = 2'b01 the result is A OR B', with B' as in R1.
- R3: With op_i = 2'b10 and sub_i = 0 the result is A + B modulo 2^32.
- R4: With op_i = 2'b10 and sub_i = 1 the result is A - B modulo 2^32, formed as A + ~B + 1.
- R5: With op_i = 2'b11 bits 31..1 of the result are 0 and bit 0 equals bit 31 of A + B' + sub_i. With sub_i = 1 this is the raw sign of A - B, with no overflow correction, so A = 0x7FFFFFFF against B = 0xFFFFFFFF gives 1.
- R6: cout_o is the carry out of bit 31 of A + B' + sub_i, whatever op_i selects.
- R7: ovf_o is 1 exactly when the carry into bit 31 differs from the carry out of bit 31, for example 0x7FFFFFFF + 1.
- R8: zero_o is 1 exactly when all 32 result bits are 0; with op_i = 2'b10 and sub_i = 1 it flags A equal to B.
- R9: set_o is bit 31 of A + B' + sub_i, whatever op_i selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 compare |
| sub_i | input | 1 | Inverts B and sets the carry into bit 0 |
| result_o | output | 32 | Selected result |
| cout_o | output | 1 | Carry out of bit 31 |
| ovf_o | output | 1 | Signed overflow of the adder |
| zero_o | output | 1 | All result bits are zero |
| set_o | output | 1 | Raw adder sum bit of the top slice |

## Verification
The assertions are immediate checks that run whenever the inputs change. They assume that op_i, sub_i and both operands always hold known 0 or 1 values and stay stable long enough for the ripple chain to settle. The stimulus sets every input together from one process, holds it, and looks at the outputs only after a settling delay. No input is ever left undriven or X.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_SUM = 2'b10,
    OP_LT  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    binv_i,
  input  logic    cin_i,
  input  logic    less_i,
  input  alu_op_e op_i,
  output logic    sum_o,
  output logic    cout_o,
  output logic    res_o
);
  logic b_eff;

  assign b_eff  = b_i ^ binv_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_eff;
      OP_OR:   res_o = a_i | b_eff;
      OP_SUM:  res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic         zero_o
);
  assign zero_o = ~|vec_i;
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         sub_i,
  output logic [W-1:0] result_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         zero_o,
  output logic         set_o
);
  localparam int MSB = W - 1;

  alu_op_e op;
  logic    msb_sum;
  logic    msb_cin;

  assign op = alu_op_e'(op_i);

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic c_in;
    logic c_out;
    logic sum;
    logic res;
    logic less;

    if (i == 0) begin : g_first
      assign c_in = sub_i;
      assign less = msb_sum;   // compare result fed back from top slice
    end else begin : g_rest
      assign c_in = g_slice[i-1].c_out;
      assign less = 1'b0;
    end

    alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .binv_i (sub_i),
      .cin_i  (c_in),
      .less_i (less),
      .op_i   (op),
      .sum_o  (sum),
      .cout_o (c_out),
      .res_o  (res)
    );

    assign result_o[i] = res;
  end

  assign msb_sum = g_slice[MSB].sum;
  assign msb_cin = g_slice[MSB].c_in;
  assign cout_o  = g_slice[MSB].c_out;
  assign ovf_o   = msb_cin ^ cout_o;
  assign set_o   = msb_sum;

  alu_zero_detect #(.W(W)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic         sub_i,
  input logic [W-1:0] result_o,
  input logic         cout_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         set_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  always_comb begin
    if (op_i == 2'b00)
      a_r1_and: assert (result_o == (a_i & b_eff)) else $error("R1 and");
    if (op_i == 2'b01)
      a_r2_or: assert (result_o == (a_i | b_eff)) else $error("R2 or");
    // covers R3 and R4
    if (op_i == 2'b10)
      a_r3_add: assert ({cout_o, result_o} == wide) else $error("R3/R4 sum");
    if (op_i == 2'b11)
      a_r5_slt: assert (result_o[W-1:1] == '0 && result_o[0] == set_o) else $error("R5 slt");
    a_r6_cout: assert (cout_o == wide[W]) else $error("R6 cout");
    if (op_i == 2'b10 && !sub_i)
      a_r7_ovf: assert (ovf_o == ((a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1])))
        else $error("R7 ovf");
    a_r8_zero: assert (zero_o == (result_o == '0)) else $error("R8 zero");
    a_r9_set: assert (set_o == wide[W-1]) else $error("R9 set");
  end
endmodule

bind alu_bitslice alu_bitslice_chk #(.W(W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .sub_i    (sub_i),
  .result_o (result_o),
  .cout_o   (cout_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o),
  .set_o    (set_o)
);

// File: tb/alu_bitslice_tb.sv
`timescale 1ns/1ps
module alu_bitslice_tb;
  logic        clk;
  logic [31:0] a, b, res;
  logic [1:0]  op;
  logic        sub, cout, ovf, zero, set;
  int          total = 0;
  int          bad   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  alu_bitslice u_dut (
    .a_i (a), .b_i (b), .op_i (op), .sub_i (sub),
    .result_o (res), .cout_o (cout), .ovf_o (ovf), .zero_o (zero), .set_o (set)
  );

  // a, b, op, sub
  localparam int NV = 16;
  localparam logic [66:0] VECS [NV] = '{
    {32'hF0F0F0F0, 32'hFF00FF00, 2'b00, 1'b0},
    {32'hF0F0F0F0, 32'hFF00FF00, 2'b00, 1'b1},
    {32'h12340000, 32'h00005678, 2'b01, 1'b0},
    {32'h0F0F0000, 32'h0F0F0000, 2'b01, 1'b1},
    {32'h00000004, 32'h00000003, 2'b10, 1'b0},
    {32'hFFFFFFFC, 32'h00000003, 2'b10, 1'b0},
    {32'hFFFFFFFC, 32'hFFFFFFFD, 2'b10, 1'b0},
    {32'h7FFFFFFF, 32'h00000001, 2'b10, 1'b0},
    {32'h80000000, 32'h80000000, 2'b10, 1'b0},
    {32'h00000004, 32'h00000003, 2'b10, 1'b1},
    {32'h80000000, 32'h00000001, 2'b10, 1'b1},
    {32'h00000005, 32'hFFFFFFF9, 2'b11, 1'b1},
    {32'hFFFFFFF9, 32'h00000005, 2'b11, 1'b1},
    {32'h7FFFFFFF, 32'hFFFFFFFF, 2'b11, 1'b1},
    {32'h12345678, 32'h12345678, 2'b10, 1'b1},
    {32'h00000005, 32'h00000007, 2'b11, 1'b0}
  };

  logic [31:0] e_res;
  logic        e_cout, e_ovf, e_zero, e_set;

  task automatic model();
    logic [31:0] be;
    logic [32:0] full;
    be     = sub ? ~b : b;
    full   = {1'b0, a} + {1'b0, be} + 33'(sub);
    e_cout = full[32];
    e_set  = full[31];
    e_ovf  = (a[31] == be[31]) && (full[31] != a[31]);
    case (op)
      2'b00:   e_res = a & be;
      2'b01:   e_res = a | be;
      2'b10:   e_res = full[31:0];
      default: e_res = {31'b0, full[31]};
    endcase
    e_zero = (e_res == 32'h0);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h op=%b sub=%b act=%h exp=%h", tag, a, b, op, sub, act, exp);
    end
  endtask

  function automatic string res_tag();
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return sub ? "R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [31:0] av, input logic [31:0] bv,
                       input logic [1:0] ov, input logic sv);
    @(negedge clk);
    a = av; b = bv; op = ov; sub = sv;
    #1;
    model();
    chk(res_tag(), res, e_res);
    chk("R6", {31'b0, cout}, {31'b0, e_cout});
    chk("R7", {31'b0, ovf},  {31'b0, e_ovf});
    chk("R8", {31'b0, zero}, {31'b0, e_zero});
    chk("R9", {31'b0, set},  {31'b0, e_set});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = 2'b00; sub = 1'b0;
    #1;
    // idle state with all-zero inputs (R1, R8)
    chk("R1", res, 32'h0);
    chk("R8", {31'b0, zero}, 32'h1);
    for (int i = 0; i < NV; i++)
      apply(VECS[i][66:35], VECS[i][34:3], VECS[i][2:1], VECS[i][0]);
    // R7 explicit: 7FFFFFFF + 1 overflows to 80000000
    apply(32'h7FFFFFFF, 32'h00000001, 2'b10, 1'b0);
    chk("R7", {31'b0, ovf}, 32'h1);
    chk("R3", res, 32'h80000000);
    // R5 raw sign, no overflow correction
    apply(32'h7FFFFFFF, 32'hFFFFFFFF, 2'b11, 1'b1);
    chk("R5", res, 32'h00000001);
    // R8 equality through subtract
    apply(32'hDEADBEEF, 32'hDEADBEEF, 2'b10, 1'b1);
    chk("R8", {31'b0, zero}, 32'h1);
    // R5 equal operands compare to 0
    apply(32'h00000000, 32'h00000000, 2'b11, 1'b1);
    chk("R5", res, 32'h0);
    // R6 carry visible under AND select
    apply(32'hFFFFFFFF, 32'h00000001, 2'b00, 1'b0);
    chk("R6", {31'b0, cout}, 32'h1);
    // R4 wrap: 0 - 1
    apply(32'h00000000, 32'h00000001, 2'b10, 1'b1);
    chk("R4", res, 32'hFFFFFFFF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule